// File: doc/BRIEF.md
# Nested Internal Interrupt Prioritizer

This block gathers fifteen on-chip interrupt sources that all sit at a single CPU priority level. It keeps three 15-bit registers, one bit per source in each:
- a pending register, which records requests;
- an enable register, which lets a pending request reach the CPU;
- an in-service register, which marks the sources whose handlers are running.

From these registers it selects one winning source. The winner is the highest-priority source that is pending and enabled, and that is not shadowed by an in-service bit at its own position or at a higher-priority position. The block raises a request line toward the level arbiter and presents a 5-bit source code, which the vector logic places in the low bits of the vector number.

When the CPU acknowledges the level, the block updates two bits of the source that won in that cycle. It clears the source's pending bit and sets its in-service bit. From then on, that source and every source below it are held off, while sources above it can still interrupt. This is how handlers nest inside one level. Software reads all three registers through a small register port. It clears pending and in-service bits by writing ones, and it writes the enable register directly.

Each source input is a level request that is sampled on every clock edge. Each source also has an event-enable input. When a peripheral drops that input, the pending bit of its source is cleared and kept clear.

Top module: `irq_nest_top`

## Requirements
- R1: After a synchronous active-high reset, the following are all zero: the pending, enable and in-service registers, `req_o` and `vec_code_o`.
- R2: A source whose `src_req` bit is high at a clock edge, and whose `evt_en` bit is high, has its pending bit set after that edge. This happens whether or not its enable bit is set. A disabled source never raises `req_o`.
- R3: Priority is fixed, and bit 0 has the highest priority. The bits in falling priority are: 0 and 1 (general-purpose inputs 3 and 2), 3 (serial channel 1), 5 (general-purpose input 1), 6 (timer 2), 8 (serial peripheral port), 9 (timer 3), 11 and 12 (management channels 1 and 2), and 14 (general-purpose input 0). The winner's code on `vec_code_o` is 15 minus its bit index, so bit 0 gives 15 and bit 14 gives 1.
- R4: `req_o` is high exactly when some source is pending, enabled and not blocked. While `req_o` is low, `vec_code_o` is 00000.
- R5: An edge with `ack_i` high while `req_o` is high clears the winner's pending bit and sets its in-service bit.
- R6: An in-service bit at index k blocks every source with index k or above, meaning its own source and all lower-priority sources. Sources with an index below k still request.
- R7: The register port has three writable addresses. A write to address 0 clears the pending bits under ones in the data. A write to address 2 clears the in-service bits the same way. A write to address 1 loads the enable register.
- R8: An acknowledge while `req_o` is low changes neither the pending register nor the in-service register, and the code presented is 00000.
- R9: While a source's `evt_en` bit is low, its pending bit is cleared at the next edge and stays clear, even when its `src_req` bit is high.
- R10: `rd_data` returns the register selected by `rd_addr`: 0 for pending, 1 for enable, 2 for in-service. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 15 | Level request from each source |
| evt_en | input | 15 | Event enable from each source; low clears and holds off pending |
| ack_i | input | 1 | Acknowledge of the internal level |
| req_o | output | 1 | Request toward the level arbiter |
| vec_code_o | output | 5 | Source code of the current winner, 00000 if none |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 15 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 15 | Register read data |

## Verification
The assertions check the following on every cycle:
- a grant is at most one-hot;
- a request implies an enabled pending source;
- the grant always sits above the highest-priority in-service bit;
- in-service bits rise only through an acknowledge;
- pending bits capture incoming requests and drop under a low event enable;
- an acknowledge with no request leaves the in-service register untouched.

Other behaviours can only be shown by the bench's scenarios. These are the exact priority order and code values, preemption of a running handler by a higher source, software clearing that releases lower sources, polling with sources disabled, and the read port's address decoding.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NSRC   = 15;
    localparam int CODE_W = $clog2(NSRC + 1);
    localparam int ADDR_W = 2;

    typedef logic [NSRC-1:0]   src_vec_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PEND = 2'd0,
        SEL_ENAB = 2'd1,
        SEL_SVC  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     valid;
        code_t    code;
        src_vec_t onehot;
    } pick_t;

    typedef struct packed {
        src_vec_t pend_clr;
        src_vec_t svc_clr;
        logic     enab_wr;
        src_vec_t enab_val;
    } sw_cmd_t;

    // Source code from priority position: highest position gets largest code.
    function automatic code_t code_of(input int idx);
        return code_t'(NSRC - idx);
    endfunction

    // Spread every in-service bit toward lower priority (higher index).
    function automatic src_vec_t block_spread(input src_vec_t svc);
        src_vec_t out;
        out[0] = svc[0];
        for (int i = 1; i < NSRC; i++) begin
            out[i] = out[i-1] | svc[i];
        end
        return out;
    endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_nest_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t src_req,
    input  src_vec_t evt_en,
    input  src_vec_t sw_clr,
    input  src_vec_t ack_clr,
    output src_vec_t pend
);

    src_vec_t pend_q;
    src_vec_t pend_d;

    always_comb begin
        pend_d = ((pend_q & ~sw_clr & ~ack_clr) | src_req) & evt_en;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend = pend_q;

    // R2
    pend_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ((src_req & evt_en) != '0) |=>
        ((pend & $past(src_req & evt_en)) == $past(src_req & evt_en)));

    // R9
    evt_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((~evt_en) != '0) |=> ((pend & $past(~evt_en)) == '0));

endmodule

// File: rtl/irq_svc_reg.sv
module irq_svc_reg
    import irq_nest_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t sw_clr,
    input  src_vec_t ack_set,
    output src_vec_t svc
);

    src_vec_t svc_q;

    always_ff @(posedge clk) begin
        if (rst) svc_q <= '0;
        else     svc_q <= (svc_q & ~sw_clr) | ack_set;
    end

    assign svc = svc_q;

    // R5
    svc_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ((svc & ~$past(svc)) != '0) |-> ((svc & ~$past(svc)) == $past(ack_set)));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_nest_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pend,
    input  src_vec_t enab,
    input  src_vec_t svc,
    output pick_t    pick
);

    src_vec_t blocked;
    src_vec_t elig;
    src_vec_t svc_top;

    always_comb begin
        blocked = block_spread(svc);
        elig    = pend & enab & ~blocked;
    end

    // Lowest index wins: scan from the bottom, later (higher) hits overwrite.
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pick.valid  = 1'b1;
                pick.code   = code_of(i);
                pick.onehot = src_vec_t'(1) << i;
            end
        end
    end

    assign svc_top = svc & (~svc + src_vec_t'(1));

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick.onehot));

    // R4
    req_source_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> (((pend & enab) != '0) && (pick.code != '0)));

    // R6
    nest_order_chk: assert property (@(posedge clk) disable iff (rst)
        (pick.valid && (svc != '0)) |-> (pick.onehot < svc_top));

endmodule

// File: rtl/irq_nest_top.sv
module irq_nest_top
    import irq_nest_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [14:0] src_req,
    input  logic [14:0] evt_en,
    input  logic        ack_i,
    output logic        req_o,
    output logic [4:0]  vec_code_o,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [14:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [14:0] rd_data
);

    sw_cmd_t  cmd;
    src_vec_t pend;
    src_vec_t svc;
    src_vec_t enab_q;
    src_vec_t ack_hit;
    pick_t    pick;

    always_comb begin
        cmd = '0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                SEL_PEND: cmd.pend_clr = wr_data;
                SEL_SVC:  cmd.svc_clr  = wr_data;
                SEL_ENAB: begin
                    cmd.enab_wr  = 1'b1;
                    cmd.enab_val = wr_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              enab_q <= '0;
        else if (cmd.enab_wr) enab_q <= cmd.enab_val;
    end

    assign ack_hit = (ack_i && pick.valid) ? pick.onehot : '0;

    irq_pend_reg u_pend (
        .clk     (clk),
        .rst     (rst),
        .src_req (src_req),
        .evt_en  (evt_en),
        .sw_clr  (cmd.pend_clr),
        .ack_clr (ack_hit),
        .pend    (pend)
    );

    irq_svc_reg u_svc (
        .clk     (clk),
        .rst     (rst),
        .sw_clr  (cmd.svc_clr),
        .ack_set (ack_hit),
        .svc     (svc)
    );

    irq_pick u_pick (
        .clk  (clk),
        .rst  (rst),
        .pend (pend),
        .enab (enab_q),
        .svc  (svc),
        .pick (pick)
    );

    assign req_o      = pick.valid;
    assign vec_code_o = pick.valid ? pick.code : '0;

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            SEL_PEND: rd_data = pend;
            SEL_ENAB: rd_data = enab_q;
            SEL_SVC:  rd_data = svc;
            default:  rd_data = '0;
        endcase
    end

    // R8
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !req_o && !wr_en) |=> (svc == $past(svc)));

    // R5
    ack_take_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && req_o && !wr_en) |=> ((svc & $past(pick.onehot)) != '0));

endmodule

// File: tb/irq_nest_top_bench.sv
module irq_nest_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] src_req = '0;
    logic [14:0] evt_en = '1;
    logic        ack_i = 1'b0;
    logic        req_o;
    logic [4:0]  vec_code_o;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [14:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [14:0] rd_data;

    irq_nest_top u_irq_nest_top (
        .clk (clk), .rst (rst), .src_req (src_req), .evt_en (evt_en),
        .ack_i (ack_i), .req_o (req_o), .vec_code_o (vec_code_o),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data)
    );

    always #5 clk = ~clk;

    typedef struct {
        string       tag;
        logic [1:0]  addr;
        logic [14:0] rd;
        logic        req;
        logic [4:0]  code;
    } exp_t;

    exp_t exp_q[$];
    event go;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    // Monitor: pops one expected item per trigger and compares the ports.
    initial begin
        forever begin
            @(go);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (rd_data !== e.rd || req_o !== e.req || vec_code_o !== e.code) begin
                    n_bad++;
                    $display("FAIL %s addr=%0d: rd=%h req=%b code=%0d, expected rd=%h req=%b code=%0d",
                             e.tag, e.addr, rd_data, req_o, vec_code_o, e.rd, e.req, e.code);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_item(input string tag, input logic [1:0] a,
                               input logic [14:0] rd, input logic rq, input logic [4:0] cd);
        exp_t e;
        rd_addr = a;
        #1;
        e.tag = tag; e.addr = a; e.rd = rd; e.req = rq; e.code = cd;
        exp_q.push_back(e);
        ->go;
        #1;
    endtask

    task automatic pulse_src(input logic [14:0] v);
        src_req = v;
        step();
        src_req = '0;
    endtask

    task automatic ack_pulse();
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [14:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1: reset state
        expect_item("R1", 2'd0, 15'h0000, 1'b0, 5'd0);
        expect_item("R1", 2'd1, 15'h0000, 1'b0, 5'd0);
        expect_item("R1", 2'd2, 15'h0000, 1'b0, 5'd0);

        // R2: disabled source records pending, no request
        pulse_src(15'h0008);
        expect_item("R2", 2'd0, 15'h0008, 1'b0, 5'd0);

        // R7 / R4: enable all, request appears with code 12
        wr(2'd1, 15'h7FFF);
        expect_item("R7", 2'd1, 15'h7FFF, 1'b1, 5'd12);

        // R3: bit 3 beats bits 9 and 12
        pulse_src(15'h1200);
        expect_item("R3", 2'd0, 15'h1208, 1'b1, 5'd12);

        // R5 / R6: ack moves bit 3 to service, lower sources blocked
        ack_pulse();
        expect_item("R5", 2'd2, 15'h0008, 1'b0, 5'd0);
        expect_item("R6", 2'd0, 15'h1200, 1'b0, 5'd0);

        // R6: higher source preempts running handler
        pulse_src(15'h0002);
        expect_item("R6", 2'd0, 15'h1202, 1'b1, 5'd14);
        ack_pulse();
        expect_item("R5", 2'd2, 15'h000A, 1'b0, 5'd0);

        // R8: ack with no request changes nothing
        ack_pulse();
        expect_item("R8", 2'd2, 15'h000A, 1'b0, 5'd0);
        expect_item("R8", 2'd0, 15'h1200, 1'b0, 5'd0);

        // R7: clear in-service bits by writing ones
        wr(2'd2, 15'h0002);
        expect_item("R7", 2'd2, 15'h0008, 1'b0, 5'd0);
        wr(2'd2, 15'h0008);
        expect_item("R7", 2'd2, 15'h0000, 1'b1, 5'd6);

        // R7: clear a pending bit
        wr(2'd0, 15'h0200);
        expect_item("R7", 2'd0, 15'h1000, 1'b1, 5'd3);

        // R9: event enable low drops a pending bit
        evt_en = 15'h7FFF & ~15'h1000;
        step();
        evt_en = '1;
        expect_item("R9", 2'd0, 15'h0000, 1'b0, 5'd0);

        // R9: event enable low holds off a live request
        src_req = 15'h0020;
        evt_en  = 15'h7FFF & ~15'h0020;
        step();
        step();
        expect_item("R9", 2'd0, 15'h0000, 1'b0, 5'd0);
        src_req = '0;
        evt_en  = '1;
        step();

        // R2: polling a disabled source
        wr(2'd1, 15'h3FFF);
        pulse_src(15'h4000);
        expect_item("R2", 2'd0, 15'h4000, 1'b0, 5'd0);
        wr(2'd1, 15'h7FFF);
        expect_item("R3", 2'd0, 15'h4000, 1'b1, 5'd1);

        // R3: highest source gets code 15
        pulse_src(15'h0001);
        expect_item("R3", 2'd0, 15'h4001, 1'b1, 5'd15);
        ack_pulse();
        expect_item("R6", 2'd2, 15'h0001, 1'b0, 5'd0);
        expect_item("R6", 2'd0, 15'h4000, 1'b0, 5'd0);

        // R10: unused address reads zero
        expect_item("R10", 2'd3, 15'h0000, 1'b0, 5'd0);

        wr(2'd0, 15'h4000);
        wr(2'd2, 15'h0001);
        expect_item("R7", 2'd0, 15'h0000, 1'b0, 5'd0);
        expect_item("R7", 2'd2, 15'h0000, 1'b0, 5'd0);

        step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule